// File: doc/BRIEF.md
# Video Control Port Command Decoder

This block sits behind the 16-bit control port of a tile-based video processor. Each word written there is either a one-word register write or one half of a two-word access command. Register writes fill a small register file: four mode bytes, the address step, the 16-bit DMA length and the three DMA source bytes. A two-word command is assembled into a 6-bit access code and a 16-bit destination address. The block also names the memory being addressed: pattern RAM, colour RAM or vertical-scroll RAM.

From each completed command the block decides whether a DMA starts at once, as a memory-to-video or copy transfer, or whether a fill is armed. An armed fill starts on the next data-port write and uses that word as its fill value. A request pulses for one cycle and carries its kind. A busy flag stays high until the mover that runs the transfer reports completion. The status word that the control port returns on reads is a constant pattern with the busy flag merged in. The data movement itself happens elsewhere.

Top module: `vdp_ctrl_decoder`

## Requirements
- R1: A control word whose bits 15:14 are 2'b10 writes its bits 7:0 into the register selected by bits 12:8, visible from the cycle after the write. Index 0x00/0x01/0x0B/0x0C drive mode_a/b/c/d and index 0x0F drives auto_inc. Such a write leaves a pending first command half untouched.
- R2: Any other control word is latched as a first half when none is pending, which raises cmd_pending. When a first half is pending, the word completes the command: cmd_valid pulses for one cycle and cmd_pending falls.
- R3: On completion cmd_code = {second[7:4], first[15:14]} and cmd_addr = {second[1:0], first[13:0]}.
- R4: cmd_target is 0 (pattern RAM) when cmd_code & 6'h0E is 0, 2 (vertical-scroll RAM) when it is 6'h04, and 1 (colour RAM) otherwise.
- R5: A completed command with code bits 5:4 = 2'b11 raises dma_req with dma_kind 3 (copy) in the same cycle as cmd_valid.
- R6: A completed command with code bits 5:4 = 2'b10 raises dma_req with dma_kind 1 (memory) when register 0x17 bit 7 is 0, and raises no request when it is 1.
- R7: While the latest code has bits 5:4 = 2'b10, a data-port write raises dma_req with dma_kind 2 (fill), sets fill_value to the data word and drops a pending first half. With any other code a data-port write raises no request.
- R8: dma_src = {reg17[6:0] & mask, reg16, reg15, 1'b0}, with mask 7'h7F when reg17 bit 7 is 0 and 7'h3F otherwise. xfer_bits = reg17[7:6].
- R9: dma_len = {reg14, reg13}, and a write to either byte changes only that byte.
- R10: status_word reads 16'h3600 when idle and 16'h3602 while busy. Busy rises together with dma_req and falls in the cycle after dma_done is seen without a new request.
- R11: Register writes to indices 0x06, 0x08, 0x09, 0x0E and to any index above 0x17 change no register output.
- R12: After reset all register outputs, cmd_code, cmd_addr, cmd_target, dma_kind and fill_value are 0, and cmd_pending, cmd_valid, dma_req and dma_busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_wdata | input | 16 | Control-port write word |
| data_wr | input | 1 | Data-port write strobe |
| data_wdata | input | 16 | Data-port write word |
| dma_done | input | 1 | Transfer finished, clears busy |
| status_word | output | 16 | Value returned by a control-port read |
| cmd_pending | output | 1 | First command half held |
| cmd_valid | output | 1 | One-cycle pulse on command completion |
| cmd_code | output | 6 | Access code of the latest command |
| cmd_addr | output | 16 | Destination address of the latest command |
| cmd_target | output | 2 | 0 pattern RAM, 1 colour RAM, 2 vertical-scroll RAM |
| dma_req | output | 1 | One-cycle transfer request |
| dma_kind | output | 2 | 1 memory, 2 fill, 3 copy |
| dma_busy | output | 1 | Transfer outstanding |
| fill_value | output | 16 | Word captured for a fill |
| mode_a | output | 8 | Mode byte, index 0x00 |
| mode_b | output | 8 | Mode byte, index 0x01 |
| mode_c | output | 8 | Mode byte, index 0x0B |
| mode_d | output | 8 | Mode byte, index 0x0C |
| auto_inc | output | 8 | Address step, index 0x0F |
| dma_len | output | 16 | Transfer length |
| dma_src | output | 24 | Transfer source byte address |
| xfer_bits | output | 2 | Transfer-type bits from index 0x17 |

## Verification
The bench feeds command pairs whose code bits sit in both words. A decoder that took the code from one word only, or that swapped the halves, would report a wrong code, address or target memory. It sets bit 7 of the high source byte both ways. A wrong mask would leave bit 6 in the source address, and an ignored bit 7 would start a memory transfer when none is due. It writes a register while a first half is pending, and it writes data while a fill is armed and a half is pending. A latch that a register write cleared, or that a fill left set, would pair the wrong words. Reserved and out-of-range indices are written to show that a decoder which aliased them would corrupt the mode, length or source bytes.

// File: rtl/vdp_ctrl_pkg.sv
package vdp_ctrl_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 5;
  localparam int CODE_W = 6;
  localparam int ADDR_W = 16;
  localparam int SRC_W  = 2 * BYTE_W + 8;

  localparam logic [IDX_W-1:0] RI_MODE_A  = 5'h00;
  localparam logic [IDX_W-1:0] RI_MODE_B  = 5'h01;
  localparam logic [IDX_W-1:0] RI_MODE_C  = 5'h0B;
  localparam logic [IDX_W-1:0] RI_MODE_D  = 5'h0C;
  localparam logic [IDX_W-1:0] RI_STEP    = 5'h0F;
  localparam logic [IDX_W-1:0] RI_LEN_LO  = 5'h13;
  localparam logic [IDX_W-1:0] RI_LEN_HI  = 5'h14;
  localparam logic [IDX_W-1:0] RI_SRC_LO  = 5'h15;
  localparam logic [IDX_W-1:0] RI_SRC_MID = 5'h16;
  localparam logic [IDX_W-1:0] RI_SRC_HI  = 5'h17;

  localparam logic [WORD_W-1:0] STATUS_IDLE = 16'h3600;

  typedef enum logic [1:0] {TGT_PATTERN = 2'd0, TGT_COLOUR = 2'd1, TGT_VSCROLL = 2'd2} tgt_e;
  typedef enum logic [1:0] {DK_NONE = 2'd0, DK_MEM = 2'd1, DK_FILL = 2'd2, DK_COPY = 2'd3} dkind_e;

  function automatic logic is_reg_write(input logic [WORD_W-1:0] w);
    return w[15:14] == 2'b10;
  endfunction

  function automatic logic [CODE_W-1:0] join_code(input logic [WORD_W-1:0] first,
                                                  input logic [WORD_W-1:0] second);
    return {second[7:4], first[15:14]};
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [WORD_W-1:0] first,
                                                  input logic [WORD_W-1:0] second);
    return {second[1:0], first[13:0]};
  endfunction

  function automatic logic [1:0] pick_target(input logic [CODE_W-1:0] code);
    logic [2:0] sel;
    sel = code[3:1];
    if (sel == 3'd0)      return TGT_PATTERN;
    else if (sel == 3'd2) return TGT_VSCROLL;
    else                  return TGT_COLOUR;
  endfunction

  function automatic logic [SRC_W-1:0] src_address(input logic [BYTE_W-1:0] hi,
                                                   input logic [BYTE_W-1:0] mid,
                                                   input logic [BYTE_W-1:0] lo);
    logic [6:0] keep;
    keep = hi[7] ? 7'h3F : 7'h7F;
    return {hi[6:0] & keep, mid, lo, 1'b0};
  endfunction

  function automatic logic [WORD_W-1:0] status_of(input logic busy);
    return STATUS_IDLE | {{(WORD_W-2){1'b0}}, busy, 1'b0};
  endfunction
endpackage

// File: rtl/vdp_regfile.sv
module vdp_regfile
  import vdp_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] mode_a,
  output logic [BYTE_W-1:0] mode_b,
  output logic [BYTE_W-1:0] mode_c,
  output logic [BYTE_W-1:0] mode_d,
  output logic [BYTE_W-1:0] step,
  output logic [BYTE_W-1:0] len_lo,
  output logic [BYTE_W-1:0] len_hi,
  output logic [BYTE_W-1:0] src_lo,
  output logic [BYTE_W-1:0] src_mid,
  output logic [BYTE_W-1:0] src_hi
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_a <= '0; mode_b <= '0; mode_c <= '0; mode_d <= '0;
      step   <= '0; len_lo <= '0; len_hi <= '0;
      src_lo <= '0; src_mid <= '0; src_hi <= '0;
    end else if (wr_en) begin
      // indices without storage here (reserved or beyond 0x17) fall to default
      case (idx)
        RI_MODE_A:  mode_a  <= wdata;
        RI_MODE_B:  mode_b  <= wdata;
        RI_MODE_C:  mode_c  <= wdata;
        RI_MODE_D:  mode_d  <= wdata;
        RI_STEP:    step    <= wdata;
        RI_LEN_LO:  len_lo  <= wdata;
        RI_LEN_HI:  len_hi  <= wdata;
        RI_SRC_LO:  src_lo  <= wdata;
        RI_SRC_MID: src_mid <= wdata;
        RI_SRC_HI:  src_hi  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vdp_cmd_latch.sv
module vdp_cmd_latch
  import vdp_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [WORD_W-1:0] ctl_wdata,
  input  logic              drop_half,
  output logic              cmpl_evt,
  output logic [CODE_W-1:0] cmpl_code,
  output logic              pending,
  output logic              valid,
  output logic [CODE_W-1:0] code,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        target
);
  logic [WORD_W-1:0] first_q;
  logic              half_wr;

  always_comb begin
    half_wr   = ctl_wr && !is_reg_write(ctl_wdata);
    cmpl_evt  = half_wr && pending;
    cmpl_code = join_code(first_q, ctl_wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      first_q <= '0;
      valid   <= 1'b0;
      code    <= '0;
      addr    <= '0;
      target  <= TGT_PATTERN;
    end else begin
      valid <= cmpl_evt;
      if (half_wr) begin
        if (!pending) begin
          pending <= 1'b1;
          first_q <= ctl_wdata;
        end else begin
          pending <= 1'b0;
          code    <= cmpl_code;
          addr    <= join_addr(first_q, ctl_wdata);
          target  <= pick_target(cmpl_code);
        end
      end else if (drop_half) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vdp_dma_ctl.sv
module vdp_dma_ctl
  import vdp_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmpl_evt,
  input  logic [CODE_W-1:0] cmpl_code,
  input  logic [CODE_W-1:0] cur_code,
  input  logic              ext_bus_off,
  input  logic              data_wr,
  input  logic [WORD_W-1:0] data_wdata,
  input  logic              dma_done,
  output logic              start_cmd,
  output logic              start_fill,
  output logic              req,
  output logic [1:0]        kind,
  output logic              busy,
  output logic [WORD_W-1:0] fill_value
);
  always_comb begin
    start_cmd  = cmpl_evt && cmpl_code[5] && (cmpl_code[4] || !ext_bus_off);
    start_fill = data_wr && (cur_code[5:4] == 2'b10);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req        <= 1'b0;
      kind       <= DK_NONE;
      busy       <= 1'b0;
      fill_value <= '0;
    end else begin
      req <= start_cmd || start_fill;
      if (start_cmd) begin
        kind <= cmpl_code[4] ? DK_COPY : DK_MEM;
        busy <= 1'b1;
      end else if (start_fill) begin
        kind       <= DK_FILL;
        fill_value <= data_wdata;
        busy       <= 1'b1;
      end else if (dma_done) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vdp_ctrl_decoder.sv
module vdp_ctrl_decoder
  import vdp_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [WORD_W-1:0] ctl_wdata,
  input  logic              data_wr,
  input  logic [WORD_W-1:0] data_wdata,
  input  logic              dma_done,
  output logic [WORD_W-1:0] status_word,
  output logic              cmd_pending,
  output logic              cmd_valid,
  output logic [CODE_W-1:0] cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [1:0]        cmd_target,
  output logic              dma_req,
  output logic [1:0]        dma_kind,
  output logic              dma_busy,
  output logic [WORD_W-1:0] fill_value,
  output logic [BYTE_W-1:0] mode_a,
  output logic [BYTE_W-1:0] mode_b,
  output logic [BYTE_W-1:0] mode_c,
  output logic [BYTE_W-1:0] mode_d,
  output logic [BYTE_W-1:0] auto_inc,
  output logic [WORD_W-1:0] dma_len,
  output logic [SRC_W-1:0]  dma_src,
  output logic [1:0]        xfer_bits
);
  // named internal events, also observed by the bound checker
  logic              reg_wr_evt;
  logic              cmd_cmpl_evt;
  logic              fill_evt;
  logic              cmd_start_evt;
  logic [CODE_W-1:0] cmpl_code;
  logic [BYTE_W-1:0] len_lo, len_hi, src_lo, src_mid, src_hi;

  assign reg_wr_evt = ctl_wr && is_reg_write(ctl_wdata);

  vdp_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_evt),
    .idx(ctl_wdata[12:8]), .wdata(ctl_wdata[7:0]),
    .mode_a(mode_a), .mode_b(mode_b), .mode_c(mode_c), .mode_d(mode_d),
    .step(auto_inc), .len_lo(len_lo), .len_hi(len_hi),
    .src_lo(src_lo), .src_mid(src_mid), .src_hi(src_hi)
  );

  vdp_cmd_latch u_cmd (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .drop_half(fill_evt), .cmpl_evt(cmd_cmpl_evt), .cmpl_code(cmpl_code),
    .pending(cmd_pending), .valid(cmd_valid), .code(cmd_code),
    .addr(cmd_addr), .target(cmd_target)
  );

  vdp_dma_ctl u_dma (
    .clk(clk), .rst_n(rst_n), .cmpl_evt(cmd_cmpl_evt), .cmpl_code(cmpl_code),
    .cur_code(cmd_code), .ext_bus_off(src_hi[7]),
    .data_wr(data_wr), .data_wdata(data_wdata), .dma_done(dma_done),
    .start_cmd(cmd_start_evt), .start_fill(fill_evt),
    .req(dma_req), .kind(dma_kind), .busy(dma_busy), .fill_value(fill_value)
  );

  always_comb begin
    dma_len     = {len_hi, len_lo};
    dma_src     = src_address(src_hi, src_mid, src_lo);
    xfer_bits   = src_hi[7:6];
    status_word = status_of(dma_busy);
  end
endmodule

// File: rtl/vdp_ctrl_checker.sv
module vdp_ctrl_checker
  import vdp_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr,
  input logic [WORD_W-1:0] ctl_wdata,
  input logic              data_wr,
  input logic              dma_done,
  input logic              reg_wr_evt,
  input logic              fill_evt,
  input logic [WORD_W-1:0] status_word,
  input logic              cmd_pending,
  input logic              cmd_valid,
  input logic [CODE_W-1:0] cmd_code,
  input logic [1:0]        cmd_target,
  input logic              dma_req,
  input logic [1:0]        dma_kind,
  input logic              dma_busy,
  input logic [BYTE_W-1:0] mode_a,
  input logic [BYTE_W-1:0] mode_b,
  input logic [BYTE_W-1:0] mode_c,
  input logic [BYTE_W-1:0] mode_d,
  input logic [BYTE_W-1:0] auto_inc,
  input logic [WORD_W-1:0] dma_len,
  input logic [SRC_W-1:0]  dma_src
);
  logic unmapped_wr;
  assign unmapped_wr = reg_wr_evt &&
    ((ctl_wdata[12:8] == 5'h06) || (ctl_wdata[12:8] == 5'h08) ||
     (ctl_wdata[12:8] == 5'h09) || (ctl_wdata[12:8] == 5'h0E) ||
     (ctl_wdata[12:8] > 5'h17));

  p_valid_clears_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !cmd_pending);

  p_pending_from_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_pending) |-> ($past(ctl_wr) && $past(ctl_wdata[15:14]) != 2'b10));

  p_target_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_target != 2'd3));

  p_copy_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code[5:4] == 2'b11) |-> (dma_req && dma_kind == 2'd3));

  p_fill_from_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_kind == 2'd2) |-> $past(data_wr));

  p_fill_drops_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_evt && !ctl_wr) |=> !cmd_pending);

  p_req_sets_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dma_busy && status_word[1]));

  p_done_clears_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dma_done) && !dma_req) |-> !dma_busy);

  p_unmapped_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_wr |=> ($stable(mode_a) && $stable(mode_b) && $stable(mode_c) &&
                     $stable(mode_d) && $stable(auto_inc) && $stable(dma_len) &&
                     $stable(dma_src)));
endmodule

bind vdp_ctrl_decoder vdp_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .data_wr(data_wr), .dma_done(dma_done), .reg_wr_evt(reg_wr_evt),
  .fill_evt(fill_evt), .status_word(status_word), .cmd_pending(cmd_pending),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_target(cmd_target),
  .dma_req(dma_req), .dma_kind(dma_kind), .dma_busy(dma_busy),
  .mode_a(mode_a), .mode_b(mode_b), .mode_c(mode_c), .mode_d(mode_d),
  .auto_inc(auto_inc), .dma_len(dma_len), .dma_src(dma_src)
);

// File: tb/tb_vdp_ctrl_decoder.sv
module tb_vdp_ctrl_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic        data_wr = 1'b0;
  logic [15:0] data_wdata = '0;
  logic        dma_done = 1'b0;
  logic [15:0] status_word;
  logic        cmd_pending, cmd_valid;
  logic [5:0]  cmd_code;
  logic [15:0] cmd_addr;
  logic [1:0]  cmd_target;
  logic        dma_req;
  logic [1:0]  dma_kind;
  logic        dma_busy;
  logic [15:0] fill_value;
  logic [7:0]  mode_a, mode_b, mode_c, mode_d, auto_inc;
  logic [15:0] dma_len;
  logic [23:0] dma_src;
  logic [1:0]  xfer_bits;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  vdp_ctrl_decoder dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata), .dma_done(dma_done),
    .status_word(status_word), .cmd_pending(cmd_pending), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_target(cmd_target),
    .dma_req(dma_req), .dma_kind(dma_kind), .dma_busy(dma_busy),
    .fill_value(fill_value), .mode_a(mode_a), .mode_b(mode_b), .mode_c(mode_c),
    .mode_d(mode_d), .auto_inc(auto_inc), .dma_len(dma_len), .dma_src(dma_src),
    .xfer_bits(xfer_bits)
  );

  // {reg17, first word, second word, code, addr, target, kind}
  localparam int NV = 8;
  localparam logic [65:0] VEC [NV] = '{
    {8'h00, 16'h4000, 16'h0000, 6'h01, 16'h0000, 2'd0, 2'd0},
    {8'h00, 16'hC000, 16'h0000, 6'h03, 16'h0000, 2'd1, 2'd0},
    {8'h00, 16'h5234, 16'h0010, 6'h05, 16'h1234, 2'd2, 2'd0},
    {8'h00, 16'h7FFF, 16'h0083, 6'h21, 16'hFFFF, 2'd0, 2'd1},
    {8'h80, 16'h4000, 16'h0080, 6'h21, 16'h0000, 2'd0, 2'd0},
    {8'h80, 16'h0000, 16'h00C1, 6'h30, 16'h4000, 2'd0, 2'd3},
    {8'h00, 16'hC000, 16'h0020, 6'h0B, 16'h0000, 2'd1, 2'd0},
    {8'h00, 16'h0000, 16'h0000, 6'h00, 16'h0000, 2'd0, 2'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctl(input logic [15:0] w);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = w;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic dat(input logic [15:0] w);
    @(negedge clk); data_wr = 1'b1; data_wdata = w;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk(status_word == 16'h3600, "R12 status", status_word, 16'h3600);
    chk({cmd_pending, cmd_valid, dma_req, dma_busy} == 4'b0, "R12 flags",
        {cmd_pending, cmd_valid, dma_req, dma_busy}, 0);
    chk({mode_a, mode_b, mode_c, mode_d, auto_inc} == '0, "R12 modes",
        {mode_a, mode_b, mode_c, mode_d}, 0);
    chk({dma_len, dma_src, cmd_code, cmd_addr, cmd_target, dma_kind, fill_value} == '0,
        "R12 fields", {dma_len, cmd_addr}, 0);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      ctl(16'h9700 | {8'h00, VEC[i][65:58]});
      ctl(VEC[i][57:42]);
      chk(cmd_pending == 1'b1, "R2 first half held", cmd_pending, 1);
      chk(cmd_valid == 1'b0, "R2 no valid on first half", cmd_valid, 0);
      ctl(VEC[i][41:26]);
      chk(cmd_valid == 1'b1 && cmd_pending == 1'b0, "R2 completion",
          {cmd_valid, cmd_pending}, 2'b10);
      chk(cmd_code == VEC[i][25:20], "R3 code", cmd_code, VEC[i][25:20]);
      chk(cmd_addr == VEC[i][19:4], "R3 addr", cmd_addr, VEC[i][19:4]);
      chk(cmd_target == VEC[i][3:2], "R4 target", cmd_target, VEC[i][3:2]);
      chk(dma_req == (VEC[i][1:0] != 2'd0), "R5 R6 request", dma_req, VEC[i][1:0] != 2'd0);
      if (VEC[i][1:0] != 2'd0)
        chk(dma_kind == VEC[i][1:0], "R5 R6 kind", dma_kind, VEC[i][1:0]);
      @(negedge clk);
      chk(cmd_valid == 1'b0 && dma_req == 1'b0, "R2 one-cycle pulses", {cmd_valid, dma_req}, 0);
      done_pulse();
      chk(dma_busy == 1'b0, "R10 busy clear", dma_busy, 0);
    end

    // R7 data write with a non-fill code
    dat(16'h1111);
    chk(dma_req == 1'b0, "R7 no fill for other code", dma_req, 0);

    // R1 register writes and pending half kept
    ctl(16'h8104); ctl(16'h8B0C); ctl(16'h8C81); ctl(16'h8033); ctl(16'h8F02);
    chk(mode_b == 8'h04 && mode_c == 8'h0C, "R1 mode b c", {mode_b, mode_c}, 16'h040C);
    chk(mode_d == 8'h81 && mode_a == 8'h33, "R1 mode d a", {mode_d, mode_a}, 16'h8133);
    chk(auto_inc == 8'h02, "R1 step", auto_inc, 8'h02);
    ctl(16'h4000);
    ctl(16'h8F04);
    chk(cmd_pending == 1'b1 && auto_inc == 8'h04, "R1 keeps pending half",
        {cmd_pending, auto_inc}, 9'h104);
    ctl(16'h0000);
    chk(cmd_valid && cmd_code == 6'h01, "R1 pairs original half", cmd_code, 6'h01);

    // R9 length bytes
    ctl(16'h9312); ctl(16'h94AB);
    chk(dma_len == 16'hAB12, "R9 length", dma_len, 16'hAB12);
    ctl(16'h9334);
    chk(dma_len == 16'hAB34, "R9 low byte only", dma_len, 16'hAB34);

    // R8 source address and mask
    ctl(16'h9501); ctl(16'h9602); ctl(16'h97FF);
    chk(dma_src == 24'h7E0402, "R8 masked source", dma_src, 24'h7E0402);
    chk(xfer_bits == 2'd3, "R8 type bits", xfer_bits, 3);
    ctl(16'h977F);
    chk(dma_src == 24'hFE0402, "R8 wide source", dma_src, 24'hFE0402);
    chk(xfer_bits == 2'd1, "R8 type bits low", xfer_bits, 1);

    // R11 unmapped indices
    ctl(16'h8655); ctl(16'h8855); ctl(16'h8955); ctl(16'h8E55); ctl(16'h9855); ctl(16'h9F55);
    chk({mode_a, mode_b, mode_c, mode_d} == 32'h33040C81, "R11 modes",
        {mode_a, mode_b, mode_c, mode_d}, 32'h33040C81);
    chk(auto_inc == 8'h04 && dma_len == 16'hAB34, "R11 step len", {auto_inc, dma_len}, 24'h04AB34);
    chk(dma_src == 24'hFE0402, "R11 source", dma_src, 24'hFE0402);

    // R7 fill path, R10 busy
    ctl(16'h9780); ctl(16'h4000); ctl(16'h0080);
    chk(dma_req == 1'b0, "R6 no memory DMA when bit 7 set", dma_req, 0);
    dat(16'hBEEF);
    chk(dma_req && dma_kind == 2'd2, "R7 fill request", {dma_req, dma_kind}, 3'b110);
    chk(fill_value == 16'hBEEF, "R7 fill value", fill_value, 16'hBEEF);
    chk(status_word == 16'h3602, "R10 busy status", status_word, 16'h3602);
    repeat (3) @(negedge clk);
    chk(status_word == 16'h3602, "R10 busy held", status_word, 16'h3602);
    done_pulse();
    chk(status_word == 16'h3600, "R10 idle status", status_word, 16'h3600);
    ctl(16'h4000);
    chk(cmd_pending == 1'b1, "R7 half before fill", cmd_pending, 1);
    dat(16'h1234);
    chk(cmd_pending == 1'b0 && dma_req, "R7 fill drops half", {cmd_pending, dma_req}, 2'b01);
    chk(fill_value == 16'h1234, "R7 second fill value", fill_value, 16'h1234);
    done_pulse();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule